// File: doc/BRIEF.md
# Sensor Interrupt Controller

This block gathers the event flags produced by a motion sensor's processing functions into one latched source register and turns them into two interrupt request pins. The eight sources are data-ready, watermark, overrun, single tap, double tap, activity, inactivity and free-fall. Software reaches an enable register, a pin-select register and the source register through a small register port.

Flags are cleared by read side effects. The three data-path flags clear when the output data registers are read, which the block sees as a strobe. The five motion flags clear when the source register itself is read.

Each enabled, pending source is steered to one of the two pins. All sources steered to a pin are OR'd together, and a polarity input chooses whether the pins are active-high or active-low.

Top module: `sens_irq_ctrl`

## Requirements
- R1: After reset the enable, pin-select and source registers read 0 and both pins sit at their inactive level.
- R2: Register port addresses: 0 is enable, 1 is pin-select, 2 is source (read-only; writes to it are ignored), 3 reads 0. A read returns its data on `reg_rdata_o` one cycle after `reg_re_i`. Writes to 0 and 1 take effect at the next clock edge.
- R3: Source bit positions: 0 data-ready, 1 watermark, 2 overrun, 3 single tap, 4 double tap, 5 activity, 6 inactivity, 7 free-fall. Bits 0 to 2 latch on their event whatever the enable register holds.
- R4: Bits 3 to 7 latch on their event only while their enable bit is 1.
- R5: A source bit that is set and enabled drives pin 1 when its pin-select bit is 0 and pin 2 when it is 1. Each pin is the OR of all sources routed to it.
- R6: With `pol_i` = 0 an asserted pin is 1, and with `pol_i` = 1 an asserted pin is 0.
- R7: A data read strobe clears source bits 0 to 2 and leaves bits 3 to 7 unchanged.
- R8: A read of the source register returns the value held in the read cycle. It clears those of bits 3 to 7 that it returned set, and leaves bits 0 to 2 unchanged.
- R9: An event in the same cycle as a clearing read or strobe leaves its bit set. A level held high on data-ready or watermark therefore survives a data read.
- R10: A bit 0 to 2 latched while disabled does not drive a pin until its enable bit is set. It then drives its pin without a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | W | Event inputs, one per source bit |
| data_rd_i | input | 1 | Strobe: output data registers were read |
| pol_i | input | 1 | Pin polarity: 0 active-high, 1 active-low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | W | Register write data |
| reg_rdata_o | output | W | Register read data, one cycle after the strobe |
| int1_o | output | 1 | Interrupt pin 1 |
| int2_o | output | 1 | Interrupt pin 2 |

## Verification
The bench builds the block with its defaults: eight sources, with the three low bits in the data-path class and a two-bit address. At that size every one of the 256 enable values can be swept. For each enable value all events are fired, the pins are compared over eight pin-select patterns under both polarities, and both clearing paths are then exercised.

Register readback is swept over all 256 values. Collisions between setting and clearing are driven directly on a chosen cycle, which makes the set-wins rule and the snapshot-then-clear rule directly observable.

// File: rtl/sens_irq_ctrl.sv
module sens_irq_ctrl #(
  parameter int              W         = 8,
  parameter logic [W-1:0]    DATA_MASK = 'h07,
  parameter int              AW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  evt_i,
  input  logic          data_rd_i,
  input  logic          pol_i,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [W-1:0]  reg_wdata_i,
  output logic [W-1:0]  reg_rdata_o,
  output logic          int1_o,
  output logic          int2_o
);
  localparam logic [AW-1:0] A_EN  = AW'(0);
  localparam logic [AW-1:0] A_MAP = AW'(1);
  localparam logic [AW-1:0] A_SRC = AW'(2);

  logic [W-1:0] en_q, map_q, src_q;
  logic [W-1:0] src_set, src_clr, active, rd_mux;
  logic         src_rd;

  assign src_rd  = reg_re_i && (reg_addr_i == A_SRC);
  assign src_set = evt_i & (en_q | DATA_MASK);
  assign src_clr = (src_rd ? (src_q & ~DATA_MASK) : '0)
                 | (data_rd_i ? DATA_MASK : '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) src_q <= '0;
    else        src_q <= (src_q & ~src_clr) | src_set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= '0;
      map_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_EN)  en_q  <= reg_wdata_i;
      if (reg_addr_i == A_MAP) map_q <= reg_wdata_i;
    end

  always_comb
    case (reg_addr_i)
      A_EN:    rd_mux = en_q;
      A_MAP:   rd_mux = map_q;
      A_SRC:   rd_mux = src_q;
      default: rd_mux = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        reg_rdata_o <= '0;
    else if (reg_re_i) reg_rdata_o <= rd_mux;

  assign active = src_q & en_q;
  assign int1_o = (|(active & ~map_q)) ^ pol_i;
  assign int2_o = (|(active &  map_q)) ^ pol_i;
endmodule

// File: rtl/sens_irq_ctrl_chk.sv
module sens_irq_ctrl_chk #(
  parameter int           W         = 8,
  parameter logic [W-1:0] DATA_MASK = 'h07,
  parameter int           AW        = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  evt_i,
  input logic          data_rd_i,
  input logic          pol_i,
  input logic          reg_re_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [W-1:0]  reg_rdata_o,
  input logic [W-1:0]  src_q,
  input logic [W-1:0]  en_q,
  input logic          int1_o,
  input logic          int2_o
);
  // R3
  data_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & DATA_MASK)) |=> ((src_q & $past(evt_i & DATA_MASK)) == $past(evt_i & DATA_MASK)));

  // R4
  gated_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((src_q & ~$past(src_q) & ~DATA_MASK & ~$past(en_q)) == '0));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & en_q)) |=> ((src_q & $past(evt_i & en_q)) == $past(evt_i & en_q)));

  // R7
  data_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd_i |=> ((src_q & DATA_MASK & ~$past(evt_i)) == '0));

  // R8
  snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re_i && reg_addr_i == AW'(2)) |=> (reg_rdata_o == $past(src_q)));

  // R6
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_q & en_q) == '0) |-> (int1_o == pol_i && int2_o == pol_i));
endmodule

bind sens_irq_ctrl sens_irq_ctrl_chk #(.W(W), .DATA_MASK(DATA_MASK), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .data_rd_i(data_rd_i), .pol_i(pol_i),
  .reg_re_i(reg_re_i), .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .src_q(src_q), .en_q(en_q), .int1_o(int1_o), .int2_o(int2_o)
);

// File: tb/test_sens_irq_ctrl.sv
module test_sens_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] DM = 8'h07;

  logic       clk = 0, rst_n = 0;
  logic [7:0] evt = 0, wdata = 0;
  logic       drd = 0, pol = 0, we = 0, re = 0;
  logic [1:0] addr = 0;
  logic [7:0] rdata;
  logic       int1, int2;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] m_en = 0, m_map = 0, m_src = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sens_irq_ctrl i_sens_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .data_rd_i(drd), .pol_i(pol),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .int1_o(int1), .int2_o(int2)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1; tick(); we = 0;
    if (a == 2'd0) m_en = d;
    else if (a == 2'd1) m_map = d;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; re = 1; tick(); re = 0; d = rdata;
    if (a == 2'd2) m_src = m_src & DM;
  endtask

  task automatic fire(input logic [7:0] e, input logic d_rd);
    evt = e; drd = d_rd; tick(); evt = 0; drd = 0;
    m_src = (m_src & ~(d_rd ? DM : 8'h00)) | (e & (m_en | DM));
  endtask

  task automatic chk_pins(input string tag);
    logic e1, e2;
    e1 = (|(m_src & m_en & ~m_map)) ^ pol;
    e2 = (|(m_src & m_en &  m_map)) ^ pol;
    chk({tag, " pin1"}, {7'd0, int1}, {7'd0, e1});
    chk({tag, " pin2"}, {7'd0, int2}, {7'd0, e2});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] maps [8];
    maps = '{8'h00, 8'hFF, 8'h0F, 8'hF0, 8'h55, 8'hAA, 8'h81, 8'h3C};

    repeat (3) tick();
    rst_n = 1; tick();

    // R1 reset state
    chk_pins("R1");
    rd(2'd0, d); chk("R1 enable", d, 8'h00);
    rd(2'd1, d); chk("R1 map", d, 8'h00);
    rd(2'd2, d); chk("R1 source", d, 8'h00);

    // R2 readback sweep
    for (int v = 0; v < 256; v++) begin
      wr(2'd0, v[7:0]); rd(2'd0, d); chk("R2 enable", d, v[7:0]);
      wr(2'd1, v[7:0]); rd(2'd1, d); chk("R2 map", d, v[7:0]);
    end
    wr(2'd2, 8'hFF); rd(2'd2, d); chk("R2 source write ignored", d, 8'h00);
    wr(2'd3, 8'hFF); rd(2'd3, d); chk("R2 addr3", d, 8'h00);

    // R3 R4 R5 R6 R7 R8 sweep over all enables
    for (int e = 0; e < 256; e++) begin
      wr(2'd0, e[7:0]);
      fire(8'hFF, 1'b0);
      for (int m = 0; m < 8; m++) begin
        wr(2'd1, maps[m]);
        pol = 0; #1; chk_pins("R5");
        pol = 1; #1; chk_pins("R6");
        pol = 0;
      end
      rd(2'd2, d); chk("R3 R4 latch", d, 8'hFF & (e[7:0] | DM));
      rd(2'd2, d); chk("R8 clears motion bits only", d, DM);
      chk_pins("R8 pins");
      fire(8'h00, 1'b1);
      rd(2'd2, d); chk("R7 data read clear", d, 8'h00);
    end

    // R7 motion bits untouched by data read
    wr(2'd0, 8'hFF); wr(2'd1, 8'h00);
    fire(8'hFF, 1'b0);
    fire(8'h00, 1'b1);
    rd(2'd2, d); chk("R7 keeps motion bits", d, 8'hF8);
    rd(2'd2, d); chk("R8 after clear", d, 8'h00);

    // R9 set wins over data read
    fire(8'h03, 1'b0);
    fire(8'h01, 1'b1);
    rd(2'd2, d); chk("R9 level survives data read", d, 8'h01);
    fire(8'h00, 1'b1);

    // R9 set wins over source read; R8 snapshot
    fire(8'h08, 1'b0);
    addr = 2'd2; re = 1; evt = 8'h10; tick(); re = 0; evt = 0;
    chk("R8 snapshot", rdata, 8'h08);
    m_src = 8'h10;
    rd(2'd2, d); chk("R9 event during source read", d, 8'h10);
    rd(2'd2, d); chk("R9 then cleared", d, 8'h00);

    // R10 disabled data bit latched, later enabled
    wr(2'd0, 8'h00);
    fire(8'h01, 1'b0);
    chk("R10 pin1 idle", {7'd0, int1}, 8'h00);
    wr(2'd0, 8'h01);
    chk("R10 pin1 active", {7'd0, int1}, 8'h01);
    chk_pins("R10");
    fire(8'h00, 1'b1);
    chk("R10 pin1 idle after data read", {7'd0, int1}, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule